// File: doc/BRIEF.md
# Video Processor CPU Access Port

This block is the processor-facing side of a video display controller. The host sees two byte-wide ports: a control port, which takes a byte pair that either loads the video memory pointer or writes one of the internal configuration registers, and a data port, which reads or writes video memory. Neither port touches memory directly. A data-port read hands back the contents of a single one-byte staging buffer. A data-port write drops its byte into that same buffer. The actual memory transfer and the pointer advance happen later, at the next memory access slot of a free-running sequencer.

Slots recur at a fixed spacing in system clocks. That spacing is shorter in text mode. While the screen is blanked, every clock is a slot. Nothing shields the pointer or the buffer from the host between a request and its slot. Software that hurries therefore sees the real effects: a read issued too soon after a read-address setup returns the previous buffer byte, and a read that follows a write returns the byte just written. The block contains its own video memory model, a configuration register file, and the slot sequencer.

Top module: `vdp_cpu_port`

## Requirements
- R1: After reset, the data port reads 0x00, every configuration register reads 0x00, and with neither text mode nor blanking the first slot strobe is seen 7 cycles after reset is released.
- R2: Control-port writes alternate between a first byte and a second byte. Bits 7:6 of the second byte select the action: 00 loads the pointer for reading, 01 loads the pointer for writing, and 1x copies the first byte into configuration register index = second byte bits 2:0. The pointer value is {second[5:0], first}. Control writes may be issued on back-to-back cycles.
- R3: A read-address setup requests a prefetch. At the next slot the buffer is loaded from memory at the pointer, the pointer then advances by one, and the following data read returns that byte.
- R4: A data read issued before the prefetch slot has occurred returns the old buffer contents.
- R5: A data write places its byte in the buffer immediately, so a data read before the next slot returns that same byte.
- R6: A slot with a pending write stores the buffer at the pointer and advances the pointer. A pending write is serviced before a pending read. A slot with nothing pending leaves the pointer and the buffer unchanged.
- R7: Each data read requests a new prefetch, so successive reads separated by slots return consecutive memory bytes.
- R8: The slot strobe is high in the cycle before the edge that services it. Slots are NORM_SLOT (default 8) clocks apart normally and TEXT_SLOT (default 6) clocks apart in text mode. While blank is high, every cycle is a slot.
- R9: Nothing is locked. A pointer reload or a buffer overwrite made before a slot is what that slot uses, and on a shared edge the host access takes precedence over the slot's update.
- R10: The pointer is 14 bits wide and advances from 0x3FFF to 0x0000. The memory model decodes the low VRAM_AW bits (default 12), so 0x3FFF and 0x0FFF name the same byte.
- R11: Any data-port access, read or write, returns the control port to expecting a first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| text_mode | input | 1 | Selects the shorter slot spacing |
| blank | input | 1 | Display blanked or in vertical blank: every cycle is a slot |
| cpu_ctrl_wr | input | 1 | Control-port write strobe |
| cpu_wr | input | 1 | Data-port write strobe |
| cpu_rd | input | 1 | Data-port read strobe |
| cpu_wdata | input | 8 | Host write byte for either port |
| cpu_rdata | output | 8 | Data-port read byte (staging buffer) |
| slot_tick | output | 1 | High in the cycle whose closing edge is a memory access slot |
| vreg_flat | output | NREG*8 | Configuration registers, register i at bits 8i+7:8i |

## Verification
A corrupted pointer shows up as the wrong byte on the data port one slot after the next read setup or data read, or as data landing at an unexpected location that a later readback exposes. A stale or dropped pending flag shows up within one slot period. A missing prefetch repeats the old byte, and a lost write leaves the old memory content in place. A wrong toggle phase or a wrong action decode turns a pointer load into a register write, which is visible on the register outputs one cycle later. A slot sequencer fault shows up directly as the wrong spacing of the strobe.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

  typedef enum logic [1:0] {
    SETUP_READ  = 2'b00,
    SETUP_WRITE = 2'b01,
    SETUP_REGA  = 2'b10,
    SETUP_REGB  = 2'b11
  } setup_e;

  function automatic setup_e setup_kind(input logic [7:0] second_byte);
    return setup_e'(second_byte[7:6]);
  endfunction

endpackage

// File: rtl/vcp_slot_timer.sv
module vcp_slot_timer #(
  parameter int NORM_SLOT = 8,
  parameter int TEXT_SLOT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic text_mode,
  input  logic blank,
  output logic slot_tick
);
  localparam int MAXP = (NORM_SLOT > TEXT_SLOT) ? NORM_SLOT : TEXT_SLOT;
  localparam int CW = $clog2(MAXP) + 1;
  localparam logic [CW-1:0] NLAST = CW'(NORM_SLOT - 1);
  localparam logic [CW-1:0] TLAST = CW'(TEXT_SLOT - 1);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  function automatic logic at_last(input logic [CW-1:0] c, input logic txt);
    return c >= (txt ? TLAST : NLAST);
  endfunction

  assign at_end    = at_last(cnt_q, text_mode);
  assign slot_tick = at_end || blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (slot_tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R8
  slot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !blank) |=> (!slot_tick || blank));

endmodule

// File: rtl/vcp_vram.sv
module vcp_vram #(
  parameter int VRAM_AW = 12
) (
  input  logic               clk,
  input  logic               we,
  input  logic [VRAM_AW-1:0] addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata
);
  localparam int DEPTH = 2 ** VRAM_AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/vcp_ctrl_regs.sv
module vcp_ctrl_regs #(
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RIW-1:0]    idx,
  input  logic [7:0]        wdata,
  output logic [NREG*8-1:0] regs_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [7:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         r_q <= '0;
      else if (we && idx == RIW'(i))      r_q <= wdata;
    end
    assign regs_flat[i*8 +: 8] = r_q;
  end

endmodule

// File: rtl/vdp_cpu_port.sv
module vdp_cpu_port #(
  parameter int ADDR_W    = 14,
  parameter int VRAM_AW   = 12,
  parameter int NORM_SLOT = 8,
  parameter int TEXT_SLOT = 6,
  parameter int NREG      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              text_mode,
  input  logic              blank,
  input  logic              cpu_ctrl_wr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              slot_tick,
  output logic [NREG*8-1:0] vreg_flat
);
  import vcp_pkg::*;

  localparam int RIW = $clog2(NREG);

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [7:0] second_b,
                                                  input logic [7:0] first_b);
    return ADDR_W'({second_b[5:0], first_b});
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        buf_q, first_q, mem_q;
  logic              pend_rd_q, pend_wr_q, toggle_q;

  // host operations, one per cycle: data write > data read > control
  logic op_wr, op_rd, op_ctl, ctl_second;
  logic setup_rd, setup_wr, reg_wr;
  logic svc_wr, svc_rd;
  logic [ADDR_W-1:0] ld_addr;
  setup_e kind;

  assign op_wr      = cpu_wr;
  assign op_rd      = cpu_rd && !cpu_wr;
  assign op_ctl     = cpu_ctrl_wr && !cpu_wr && !cpu_rd;
  assign ctl_second = op_ctl && toggle_q;
  assign kind       = setup_kind(cpu_wdata);
  assign setup_rd   = ctl_second && (kind == SETUP_READ);
  assign setup_wr   = ctl_second && (kind == SETUP_WRITE);
  assign reg_wr     = ctl_second && cpu_wdata[7];
  assign ld_addr    = join_addr(cpu_wdata, first_q);

  // slot service: write first, read otherwise
  assign svc_wr = slot_tick && pend_wr_q;
  assign svc_rd = slot_tick && pend_rd_q && !pend_wr_q;

  vcp_slot_timer #(.NORM_SLOT(NORM_SLOT), .TEXT_SLOT(TEXT_SLOT)) u_timer (
    .clk(clk), .rst_n(rst_n), .text_mode(text_mode), .blank(blank),
    .slot_tick(slot_tick)
  );

  vcp_vram #(.VRAM_AW(VRAM_AW)) u_vram (
    .clk(clk), .we(svc_wr), .addr(addr_q[VRAM_AW-1:0]),
    .wdata(buf_q), .rdata(mem_q)
  );

  vcp_ctrl_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_wr), .idx(cpu_wdata[RIW-1:0]),
    .wdata(first_q), .regs_flat(vreg_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      buf_q     <= '0;
      first_q   <= '0;
      pend_rd_q <= 1'b0;
      pend_wr_q <= 1'b0;
      toggle_q  <= 1'b0;
    end else begin
      if (setup_rd || setup_wr)  addr_q <= ld_addr;
      else if (svc_wr || svc_rd) addr_q <= bump(addr_q);

      if (op_wr)       buf_q <= cpu_wdata;
      else if (svc_rd) buf_q <= mem_q;

      if (op_wr)         pend_wr_q <= 1'b1;
      else if (setup_rd) pend_wr_q <= 1'b0;
      else if (svc_wr)   pend_wr_q <= 1'b0;

      if (op_wr)                  pend_rd_q <= 1'b0;
      else if (op_rd || setup_rd) pend_rd_q <= 1'b1;
      else if (setup_wr)          pend_rd_q <= 1'b0;
      else if (svc_rd)            pend_rd_q <= 1'b0;

      if (op_wr || op_rd) toggle_q <= 1'b0;
      else if (op_ctl)    toggle_q <= !toggle_q;

      if (op_ctl && !toggle_q) first_q <= cpu_wdata;
    end
  end

  assign cpu_rdata = buf_q;

  // R3
  prefetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_rd && !setup_rd && !setup_wr) |=> (addr_q == bump($past(addr_q))));

  // R3
  prefetch_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_rd && !op_wr) |=> (cpu_rdata == $past(mem_q)));

  // R5
  write_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_wr |=> (pend_wr_q && cpu_rdata == $past(cpu_wdata)));

  // R6
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && !pend_wr_q && !pend_rd_q && !cpu_wr && !cpu_rd && !cpu_ctrl_wr)
      |=> ($stable(addr_q) && $stable(cpu_rdata)));

  // R2
  write_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_wr |=> (!pend_rd_q && addr_q == $past(ld_addr)));

  // R11
  toggle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr || cpu_rd) |=> !toggle_q);

endmodule

// File: tb/test_vdp_cpu_port.sv
`timescale 1ns/1ps
module test_vdp_cpu_port;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic text_mode = 1'b0, blank = 1'b0;
  logic cpu_ctrl_wr = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic slot_tick;
  logic [NREG*8-1:0] vreg_flat;

  int checks = 0;
  int fails = 0;

  vdp_cpu_port i_vdp_cpu_port (
    .clk(clk), .rst_n(rst_n), .text_mode(text_mode), .blank(blank),
    .cpu_ctrl_wr(cpu_ctrl_wr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .slot_tick(slot_tick),
    .vreg_flat(vreg_flat)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic [7:0] b);
    cpu_ctrl_wr = 1'b1; cpu_wdata = b;
    @(negedge clk);
    cpu_ctrl_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    cpu_wr = 1'b1; cpu_wdata = b;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    cpu_rd = 1'b1; v = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic set_waddr(input logic [13:0] a);
    ctl(a[7:0]); ctl({2'b01, a[13:8]});
  endtask

  task automatic set_raddr(input logic [13:0] a);
    ctl(a[7:0]); ctl({2'b00, a[13:8]});
  endtask

  task automatic wait_slot();
    while (!slot_tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic peek(input logic [13:0] a, output logic [7:0] v);
    set_raddr(a); wait_slot(); rd(v); wait_slot();
  endtask

  task automatic gap(output int n);
    wait_slot();
    n = 1;
    while (!slot_tick) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    int n = 0;
    chk("R1 rdata after reset", cpu_rdata, 8'h00);
    chk("R1 regs after reset", int'(vreg_flat == '0), 1);
    while (!slot_tick) begin @(negedge clk); n++; end
    chk("R1 first slot", n, 7);
  endtask

  task automatic t_spacing();
    int n;
    gap(n); chk("R8 normal spacing", n, 8);
    text_mode = 1'b1; wait_slot();
    gap(n); chk("R8 text spacing", n, 6);
    text_mode = 1'b0; blank = 1'b1;
    gap(n); chk("R8 blank spacing", n, 1);
  endtask

  task automatic t_fill_seq();
    logic [7:0] v;
    blank = 1'b1;
    set_waddr(14'h100); wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
    wait_slot();
    set_waddr(14'h300); wr(8'h01); wait_slot();
    set_raddr(14'h100); wait_slot();
    rd(v); chk("R3 prefetch first", v, 8'h11);
    wait_slot(); rd(v); chk("R7 sequential second", v, 8'h22);
    wait_slot(); rd(v); chk("R7 sequential third", v, 8'h33);
  endtask

  task automatic t_idle_slot();
    logic [7:0] v;
    blank = 1'b1;
    set_raddr(14'h100); wait_slot();
    repeat (5) @(negedge clk);
    chk("R6 buffer held over idle slots", cpu_rdata, 8'h11);
    rd(v); wait_slot(); rd(v);
    chk("R6 pointer held over idle slots", v, 8'h22);
    wait_slot();
  endtask

  task automatic t_stale();
    logic [7:0] v;
    blank = 1'b0;
    set_raddr(14'h100); wait_slot(); wait_slot();
    set_raddr(14'h102);
    rd(v); chk("R4 stale read", v, 8'h11);
    wait_slot(); rd(v); chk("R3 fetched after slot", v, 8'h33);
    wait_slot();
  endtask

  task automatic t_echo();
    logic [7:0] v;
    blank = 1'b0;
    wait_slot();
    set_waddr(14'h200); wr(8'h77);
    rd(v); chk("R5 write echo", v, 8'h77);
    wait_slot(); wait_slot();
    peek(14'h200, v); chk("R6 write stored before read", v, 8'h77);
  endtask

  task automatic t_nolock();
    logic [7:0] v;
    blank = 1'b0;
    wait_slot();
    set_waddr(14'h300); wr(8'h9A); set_waddr(14'h310);
    wait_slot();
    peek(14'h310, v); chk("R9 store uses reloaded pointer", v, 8'h9A);
    peek(14'h300, v); chk("R9 old pointer untouched", v, 8'h01);
    wait_slot();
    set_waddr(14'h320); wr(8'h55); wr(8'h66);
    wait_slot();
    peek(14'h320, v); chk("R9 buffer overwrite before slot", v, 8'h66);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    blank = 1'b1;
    set_waddr(14'h3FFF); wr(8'hA1); wr(8'hA2); wait_slot();
    set_raddr(14'h3FFF); wait_slot();
    rd(v); chk("R10 top byte", v, 8'hA1);
    wait_slot(); rd(v); chk("R10 wrap to zero", v, 8'hA2);
    wait_slot();
    peek(14'h0000, v); chk("R10 zero holds wrapped write", v, 8'hA2);
    peek(14'h0FFF, v); chk("R10 mirror of top byte", v, 8'hA1);
  endtask

  task automatic t_regs();
    ctl(8'h5A); ctl(8'h83);
    chk("R2 register 3 write", vreg_flat[3*8 +: 8], 8'h5A);
    chk("R2 register 0 untouched", vreg_flat[0 +: 8], 8'h00);
    ctl(8'hC4); ctl(8'hC6);
    chk("R2 register 6 write via 11", vreg_flat[6*8 +: 8], 8'hC4);
  endtask

  task automatic t_toggle();
    logic [7:0] v;
    blank = 1'b1;
    ctl(8'h44);
    rd(v);
    set_waddr(14'h120); wr(8'hE5); wait_slot();
    peek(14'h120, v); chk("R11 toggle reset by data access", v, 8'hE5);
    chk("R11 no stray register write", int'(vreg_flat[4*8 +: 8]), 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_spacing();
    t_fill_seq();
    t_idle_slot();
    t_stale();
    t_echo();
    t_nolock();
    t_wrap();
    t_regs();
    t_toggle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule